// File: doc/BRIEF.md
# IO Isolation Handshake Sequencer

This block moves an IO pad ring into or out of isolation. A single-cycle start request, qualified by a direction bit, launches a fixed sequence. When the request is to isolate, the sequencer first forces the two pad bias power enables on. It then takes manual control of the pad ring's isolation clock through an override output and waits for the ring to acknowledge on a status input. Once the acknowledge arrives, it writes the isolate level and holds it for a guaranteed settle time. It then hands the clock back and waits for the acknowledge to drop.

Each of the two waits is a bounded poll. If the ring never answers, the sequencer abandons the attempt and releases the override. It then reports an error code that tells an isolate failure apart from a de-isolate failure, so a dead ring can never hang the controller. The poll bound and the settle time are parameters. The settle time is given in picoseconds and converted to clock cycles from the clock period.

Top module: `iso_seq_top`

## Requirements
- R1: After reset all control outputs (`pad_pwr_en_o`, `bias_pwr_en_o`, `ovr_o`, `iso_ctl_o`), `busy_o`, `done_o` and `err_o` are 0 and `err_code_o` is 0.
- R2: For an isolate request (`dir_iso_i`=1) both power enables are driven to 1 before `ovr_o` rises, and they stay 1 afterwards. A de-isolate request (`dir_iso_i`=0) leaves both enables unchanged.
- R3: The sequence runs in this order. `ovr_o` is raised. The sequencer waits until every bit of `stat_i` is 1, and a partial match does not count. It then drives `iso_ctl_o` to the direction bit, lowers `ovr_o` after the settle time, and waits until every bit of `stat_i` is 0 before reporting done.
- R4: `ovr_o` falls exactly SETTLE_CYC clock cycles after `iso_ctl_o` takes its new value, where SETTLE_CYC = max(1, ceil(SETTLE_PS / CLK_PS)).
- R5: Each wait samples `stat_i` at most POLL_MAX times. If the status never goes high, `ovr_o` stays high for exactly POLL_MAX cycles. If the status never drops, the sequencer stays busy with `ovr_o` low for exactly POLL_MAX cycles before aborting.
- R6: On an abort, `err_code_o` becomes ERR_BASE shifted left by the direction bit. With the defaults (ERR_BASE=3, 4 bits), an isolate failure gives 6 and a de-isolate failure gives 3. A successful sequence leaves the code at 0.
- R7: An abort releases `ovr_o` and drops `busy_o` in the same cycle as the error pulse, and `iso_ctl_o` keeps its previous value.
- R8: `iso_ctl_o` keeps the last value written after the sequence ends.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. It changes neither the direction nor the outcome, and it adds no extra done or error pulse.
- R10: `done_o` and `err_o` are single-cycle pulses, and exactly one of them is raised per accepted sequence.
- R11: `err_code_o` holds its value until the next accepted start, and reads 0 one cycle after that start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| dir_iso_i | input | 1 | Direction: 1 = isolate, 0 = de-isolate |
| stat_i | input | STAT_W | Acknowledge status from the pad ring |
| pad_pwr_en_o | output | 1 | Pad power enable, forced on before isolation |
| bias_pwr_en_o | output | 1 | Bias power enable, forced on before isolation |
| ovr_o | output | 1 | Isolation clock override to the pad ring |
| iso_ctl_o | output | 1 | Isolate control level to the pad ring |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| err_code_o | output | ERR_W | Sticky error code, 0 on success |

## Verification
The bench drives a small pad-ring model that follows the override with a two-cycle latency. The model can also stick low, stick high, or answer on only one of two status bits. It targets an acknowledge that never arrives, which a design without a bound would hang on. It also targets an acknowledge that never clears, where a wrong design reports the wrong code or keeps the override asserted. A half-set status must not count as a match, or isolation would be written too early. The bench measures the gap from the isolate write to the override release, which a short settle counter would cut. It also sends a stray start mid-sequence, which a careless design would use to flip direction or to emit a second pulse.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PWR    = 3'd1,
        ST_OVR    = 3'd2,
        ST_ACK_HI = 3'd3,
        ST_SETTLE = 3'd4,
        ST_ACK_LO = 3'd5
    } seq_state_e;

endpackage

// File: rtl/iso_cyc_ctr.sv
// Saturating cycle counter: flags the cycle in which LIMIT cycles of enable have been seen.
module iso_cyc_ctr #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST);

    // R5: the count never runs past the bound
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: a clear always restarts the count from zero
    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/iso_err_enc.sv
// Direction-dependent timeout code: base value shifted left by the direction bit.
module iso_err_enc #(
    parameter int              ERR_W    = 4,
    parameter logic [ERR_W-1:0] ERR_BASE = 4'd3
) (
    input  logic             dir_i,
    output logic [ERR_W-1:0] code_o
);
    always_comb begin
        if (dir_i) begin
            code_o = {ERR_BASE[ERR_W-2:0], 1'b0};
        end else begin
            code_o = ERR_BASE;
        end
    end
endmodule

// File: rtl/iso_seq_top.sv
module iso_seq_top
    import iso_seq_pkg::*;
#(
    parameter int               STAT_W    = 1,
    parameter int               POLL_MAX  = 1000000,
    parameter int               CLK_PS    = 20000,
    parameter int               SETTLE_PS = 10000,
    parameter int               ERR_W     = 4,
    parameter logic [ERR_W-1:0] ERR_BASE  = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_iso_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              pad_pwr_en_o,
    output logic              bias_pwr_en_o,
    output logic              ovr_o,
    output logic              iso_ctl_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ERR_W-1:0]  err_code_o
);
    localparam int SETTLE_RAW = (SETTLE_PS + CLK_PS - 1) / CLK_PS;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    typedef struct packed {
        seq_state_e       st;
        logic             dir;
        logic             pad;
        logic             bias;
        logic             ovr;
        logic             iso;
        logic             done;
        logic             err;
        logic [ERR_W-1:0] code;
    } seq_regs_t;

    seq_regs_t d, q;

    logic             poll_clr, poll_en, poll_last;
    logic             stl_clr, stl_en, stl_last;
    logic [ERR_W-1:0] fail_code;
    logic             ack_all_hi, ack_all_lo;

    assign ack_all_hi = (stat_i == {STAT_W{1'b1}});
    assign ack_all_lo = (stat_i == {STAT_W{1'b0}});

    iso_cyc_ctr #(.LIMIT(POLL_MAX)) i_poll_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr),
        .en_i   (poll_en),
        .last_o (poll_last)
    );

    iso_cyc_ctr #(.LIMIT(SETTLE_CYC)) i_settle_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stl_clr),
        .en_i   (stl_en),
        .last_o (stl_last)
    );

    iso_err_enc #(.ERR_W(ERR_W), .ERR_BASE(ERR_BASE)) i_err_enc (
        .dir_i  (q.dir),
        .code_o (fail_code)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        poll_clr = 1'b1;
        poll_en  = 1'b0;
        stl_clr  = 1'b1;
        stl_en   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.dir  = dir_iso_i;
                    d.code = '0;
                    d.st   = dir_iso_i ? ST_PWR : ST_OVR;
                end
            end
            ST_PWR: begin
                d.pad  = 1'b1;
                d.bias = 1'b1;
                d.st   = ST_OVR;
            end
            ST_OVR: begin
                d.ovr = 1'b1;
                d.st  = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                poll_clr = 1'b0;
                poll_en  = 1'b1;
                if (ack_all_hi) begin
                    d.iso = q.dir;
                    d.st  = ST_SETTLE;
                end else if (poll_last) begin
                    d.ovr  = 1'b0;
                    d.err  = 1'b1;
                    d.code = fail_code;
                    d.st   = ST_IDLE;
                end
            end
            ST_SETTLE: begin
                stl_clr = 1'b0;
                stl_en  = 1'b1;
                if (stl_last) begin
                    d.ovr = 1'b0;
                    d.st  = ST_ACK_LO;
                end
            end
            ST_ACK_LO: begin
                poll_clr = 1'b0;
                poll_en  = 1'b1;
                if (ack_all_lo) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (poll_last) begin
                    d.err  = 1'b1;
                    d.code = fail_code;
                    d.st   = ST_IDLE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, code: '0, default: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pad_pwr_en_o  = q.pad;
    assign bias_pwr_en_o = q.bias;
    assign ovr_o         = q.ovr;
    assign iso_ctl_o     = q.iso;
    assign busy_o        = (q.st != ST_IDLE);
    assign done_o        = q.done;
    assign err_o         = q.err;
    assign err_code_o    = q.code;

    // R2: override is only raised for isolation once both enables are on
    assert_pwr_before_ovr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovr_o) && q.dir) |-> (pad_pwr_en_o && bias_pwr_en_o));

    // R3: the isolate level only moves while the override is held
    assert_iso_under_ovr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(iso_ctl_o) |-> ovr_o);

    // R7: an abort leaves the ring with override released and the block idle
    assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!ovr_o && !busy_o));

    // R9: a start seen while busy cannot change the latched direction
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.dir));

    // R10: completion pulses are exclusive and last one cycle
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R11: the code only changes on an accepted start or on an abort
    assert_code_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_code_o));

endmodule

// File: tb/test_iso_seq_top.sv
module test_iso_seq_top;

    localparam int STAT_W    = 2;
    localparam int POLL_MAX  = 8;
    localparam int CLK_PS    = 20000;
    localparam int SETTLE_PS = 45000;
    localparam int SETTLE_EXP = 3;   // ceil(45000/20000)

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              dir_in = 1'b0;
    logic [STAT_W-1:0] stat;
    logic              pad_pwr_en_o, bias_pwr_en_o, ovr_o, iso_ctl_o;
    logic              busy_o, done_o, err_o;
    logic [3:0]        err_code_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ring_mode = 0;
    logic [1:0] pipe = 2'b00;

    always #10ns clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        pipe <= {pipe[0], ovr_o};
    end

    always_comb begin
        case (ring_mode)
            1:       stat = 2'b00;
            2:       stat = 2'b11;
            3:       stat = {1'b0, pipe[1]};
            default: stat = {2{pipe[1]}};
        endcase
    end

    iso_seq_top #(
        .STAT_W(STAT_W), .POLL_MAX(POLL_MAX), .CLK_PS(CLK_PS),
        .SETTLE_PS(SETTLE_PS), .ERR_W(4), .ERR_BASE(4'd3)
    ) i_iso_seq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dir_iso_i(dir_in),
        .stat_i(stat), .pad_pwr_en_o(pad_pwr_en_o), .bias_pwr_en_o(bias_pwr_en_o),
        .ovr_o(ovr_o), .iso_ctl_o(iso_ctl_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // results of the last sequence
    int r_done, r_err, r_ovr_hi, r_gap, r_lo_polls, r_pb_rise, r_code_busy;
    int r_busy_start, r_ended, r_pulse_after, r_pad_any;

    task automatic run_seq(input logic dir, input int mode, input int extra_at);
        logic prev_ovr, prev_iso, seen_fall;
        int iso_idx, fall_idx;
        ring_mode = mode;
        r_done = 0; r_err = 0; r_ovr_hi = 0; r_lo_polls = 0; r_pb_rise = -1;
        r_ended = 0; r_pad_any = 0;
        prev_ovr = 1'b0; prev_iso = iso_ctl_o; seen_fall = 1'b0;
        iso_idx = -1; fall_idx = -1;
        @(negedge clk); start = 1'b1; dir_in = dir;
        @(negedge clk); start = 1'b0;
        r_code_busy = int'(err_code_o);
        r_busy_start = int'(busy_o);
        for (int i = 0; i < 200; i++) begin
            if (ovr_o) r_ovr_hi++;
            if (ovr_o && !prev_ovr) r_pb_rise = int'(pad_pwr_en_o && bias_pwr_en_o);
            if (!ovr_o && prev_ovr && fall_idx < 0) begin fall_idx = i; seen_fall = 1'b1; end
            if (seen_fall && busy_o && !ovr_o) r_lo_polls++;
            if (iso_ctl_o != prev_iso && iso_idx < 0) iso_idx = i;
            if (pad_pwr_en_o || bias_pwr_en_o) r_pad_any = 1;
            if (done_o) r_done++;
            if (err_o) r_err++;
            prev_ovr = ovr_o; prev_iso = iso_ctl_o;
            if (!busy_o) begin r_ended = 1; break; end
            @(negedge clk);
            if (i + 1 == extra_at) begin start = 1'b1; dir_in = ~dir; end
            else start = 1'b0;
        end
        start = 1'b0;
        r_gap = (iso_idx >= 0 && fall_idx >= 0) ? fall_idx - iso_idx : -1;
        @(negedge clk);
        r_pulse_after = int'(done_o || err_o);
        ring_mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 pad_pwr_en", int'(pad_pwr_en_o), 0);
        chk("R1 bias_pwr_en", int'(bias_pwr_en_o), 0);
        chk("R1 ovr", int'(ovr_o), 0);
        chk("R1 iso_ctl", int'(iso_ctl_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done|err", int'(done_o || err_o), 0);
        chk("R1 code", int'(err_code_o), 0);
    endtask

    task automatic t_deiso_first;
        run_seq(1'b0, 0, -1);
        chk("R2 deisolate leaves enables off", r_pad_any, 0);
        chk("R3 deisolate completes", r_ended, 1);
        chk("R10 one done pulse", r_done, 1);
        chk("R10 no err pulse", r_err, 0);
        chk("R6 success code", int'(err_code_o), 0);
    endtask

    task automatic t_iso_ok;
        run_seq(1'b1, 0, -1);
        chk("R2 enables on at override rise", r_pb_rise, 1);
        chk("R2 pad enable held", int'(pad_pwr_en_o), 1);
        chk("R2 bias enable held", int'(bias_pwr_en_o), 1);
        chk("R4 settle gap isolate", r_gap, SETTLE_EXP);
        chk("R10 done once", r_done, 1);
        chk("R10 pulse ends", r_pulse_after, 0);
        chk("R8 iso held high", int'(iso_ctl_o), 1);
        chk("R3 override released", int'(ovr_o), 0);
    endtask

    task automatic t_deiso_ok;
        run_seq(1'b0, 0, -1);
        chk("R4 settle gap deisolate", r_gap, SETTLE_EXP);
        chk("R8 iso held low", int'(iso_ctl_o), 0);
        chk("R2 enables unchanged on deisolate", int'(pad_pwr_en_o && bias_pwr_en_o), 1);
        chk("R10 done once", r_done, 1);
    endtask

    task automatic t_iso_stuck_low;
        run_seq(1'b1, 1, -1);
        chk("R5 override held POLL_MAX", r_ovr_hi, POLL_MAX);
        chk("R7 aborted not hung", r_ended, 1);
        chk("R10 err once", r_err, 1);
        chk("R10 no done", r_done, 0);
        chk("R6 isolate fail code", int'(err_code_o), 6);
        chk("R7 iso unchanged", int'(iso_ctl_o), 0);
        chk("R7 override released", int'(ovr_o), 0);
        repeat (5) @(negedge clk);
        chk("R11 code sticky", int'(err_code_o), 6);
    endtask

    task automatic t_partial_ack;
        run_seq(1'b1, 3, -1);
        chk("R11 code cleared on start", r_code_busy, 0);
        chk("R11 start accepted", r_busy_start, 1);
        chk("R3 partial status not a match", r_err, 1);
        chk("R3 iso not written on partial", int'(iso_ctl_o), 0);
        chk("R6 partial fail code", int'(err_code_o), 6);
    endtask

    task automatic t_busy_start;
        run_seq(1'b1, 0, 2);
        chk("R9 one done only", r_done, 1);
        chk("R9 no err", r_err, 0);
        chk("R9 direction kept", int'(iso_ctl_o), 1);
        chk("R9 code stays zero", int'(err_code_o), 0);
        chk("R9 no trailing sequence", int'(busy_o), 0);
    endtask

    task automatic t_deiso_stuck_high;
        run_seq(1'b0, 2, -1);
        chk("R5 second wait POLL_MAX", r_lo_polls, POLL_MAX);
        chk("R6 deisolate fail code", int'(err_code_o), 3);
        chk("R7 iso keeps written value", int'(iso_ctl_o), 0);
        chk("R7 override released", int'(ovr_o), 0);
        chk("R10 err once", r_err, 1);
    endtask

    initial begin
        wait (cyc >= 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deiso_first();
        t_iso_ok();
        t_deiso_ok();
        t_iso_stuck_low();
        t_partial_ack();
        t_busy_start();
        t_deiso_stuck_high();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule